// File: doc/BRIEF.md
# Privilege-Gated Register Access Filter

This block sits between a simple peripheral bus slave port and a peripheral's register file, command and result tables. Every access carries a CPU privilege flag. An access made in supervisor mode always reaches its target. An access made in user mode reaches its target only when the segment it addresses is open to user code. If it is not, a user read returns all-ones and a user write is dropped. Neither raises an error.

The address space has three regions, each set by a base and size parameter:
- The global region holds configuration, test and interrupt registers. It is always supervisor-only.
- The configurable-register region and the table region are supervisor-only while an internal supervisor bit is set, and unrestricted while it is clear.
- Any address outside these three regions is treated as supervisor-only.

The supervisor bit lives in the first word of the global region and resets to 1. A supervisor write to that word updates it.

Read data passes through one registered stage, driven by a small state machine with these states:
- `ST_IDLE`: no response.
- `ST_GRANT`: returns the captured register data.
- `ST_DENY`: returns 16'hFFFF.

Its transitions are:
- `T_RD_OK`: a read that is allowed, which goes to `ST_GRANT`.
- `T_RD_BLOCK`: a read that is refused, which goes to `ST_DENY`.
- `T_NO_RD`: no read in the current cycle, which goes to `ST_IDLE`.

These three transitions are taken from any state.

Top module: `pgf_access_filter`

## Requirements
- R1: After reset the supervisor bit is 1, `rd_valid` is 0 and `rd_data` is 0, so user accesses to every region are refused.
- R2: A user read of the global region (addresses 0x00-0x07 by default) gives `rd_valid`=1 and `rd_data`=16'hFFFF in the cycle after the read, whatever the supervisor bit holds.
- R3: A user write to the global region never asserts `rf_wr_en`, whatever the supervisor bit holds.
- R4: A supervisor read of any address gives `rd_valid`=1 and `rd_data` equal to the `rf_rdata` value presented with the read, in the following cycle.
- R5: A supervisor write asserts `rf_wr_en` in the same cycle, with `rf_addr` and `rf_wdata` equal to the bus address and data.
- R6: While the supervisor bit is 1, a user read of the register region (0x08-0x1F) or the table region (0x40-0x7F) returns 16'hFFFF, and a user write there does not assert `rf_wr_en`.
- R7: While the supervisor bit is 0, user reads and writes of the register and table regions pass through exactly as supervisor accesses do.
- R8: A supervisor write to address 0x00 loads the supervisor bit from `bus_wdata[7]`, and the new value takes effect from the next cycle. A user write to 0x00 leaves the bit unchanged.
- R9: A user access to an unmapped address (0x20-0x3F or 0x80-0xFF) is refused: the read returns 16'hFFFF and the write is dropped.
- R10: `rf_rd_en` is asserted only for a read that is allowed, so a refused read has no side effect on the register file.
- R11: In a cycle that follows a cycle without a read, `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| cpu_super | input | 1 | 1 when the CPU is in supervisor mode |
| rf_rdata | input | 16 | Read data from the register file, valid in the read cycle |
| rf_addr | output | 8 | Address forwarded to the register file |
| rf_wdata | output | 16 | Write data forwarded to the register file |
| rf_wr_en | output | 1 | Qualified write enable |
| rf_rd_en | output | 1 | Qualified read enable |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 16 | Filtered read data |

## Verification
Two things can meet in one cycle: the registered response of one read, and the issue of the next access, which may be a write or read with a different privilege outcome. The bench issues accesses back to back. This makes a refused read's all-ones response appear in the same cycle that an allowed or refused write is presented. In that cycle it judges the response value and the write enable independently against expectations computed from the region and privilege of each access. The same overlap occurs when a supervisor write changes the supervisor bit and a user access follows in the next cycle. Here the bench checks that the new policy applies from that cycle on.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    typedef enum logic [1:0] {
        RG_GLOBAL = 2'd0,
        RG_CREG   = 2'd1,
        RG_TABLE  = 2'd2,
        RG_NONE   = 2'd3
    } region_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } rsp_state_t;

endpackage

// File: rtl/pgf_decode.sv
module pgf_decode
    import pgf_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int GLB_BASE = 0,
    parameter int GLB_SIZE = 8,
    parameter int REG_BASE = 8,
    parameter int REG_SIZE = 24,
    parameter int TBL_BASE = 64,
    parameter int TBL_SIZE = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    localparam int GLB_END = GLB_BASE + GLB_SIZE;
    localparam int REG_END = REG_BASE + REG_SIZE;
    localparam int TBL_END = TBL_BASE + TBL_SIZE;

    logic [31:0] a_ext;

    always_comb begin
        a_ext = 32'(addr);
        if (a_ext >= 32'(GLB_BASE) && a_ext < 32'(GLB_END))
            region = RG_GLOBAL;
        else if (a_ext >= 32'(REG_BASE) && a_ext < 32'(REG_END))
            region = RG_CREG;
        else if (a_ext >= 32'(TBL_BASE) && a_ext < 32'(TBL_END))
            region = RG_TABLE;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/pgf_policy.sv
module pgf_policy
    import pgf_pkg::*;
(
    input  region_t region,
    input  logic    cpu_super,
    input  logic    supv_bit,
    output logic    allow
);
    always_comb begin
        allow = 1'b0;
        unique case (region)
            RG_GLOBAL: allow = cpu_super;
            RG_CREG,
            RG_TABLE:  allow = cpu_super | ~supv_bit;
            RG_NONE:   allow = cpu_super;
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/pgf_supv_reg.sv
module pgf_supv_reg #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int CFG_ADDR = 0,
    parameter int SUPV_POS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              supv_bit
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            supv_bit <= 1'b1;
        else if (wr_ok && addr == ADDR_W'(CFG_ADDR))
            supv_bit <= wdata[SUPV_POS];
    end
endmodule

// File: rtl/pgf_access_filter.sv
module pgf_access_filter
    import pgf_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int GLB_BASE = 0,
    parameter int GLB_SIZE = 8,
    parameter int REG_BASE = 8,
    parameter int REG_SIZE = 24,
    parameter int TBL_BASE = 64,
    parameter int TBL_SIZE = 64,
    parameter int SUPV_POS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              cpu_super,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_wr_en,
    output logic              rf_rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] BLOCKED = {DATA_W{1'b1}};

    region_t    region;
    logic       supv_bit;
    logic       allow;
    rsp_state_t state_q, state_d;
    logic [DATA_W-1:0] cap_q;

    pgf_decode #(
        .ADDR_W(ADDR_W), .GLB_BASE(GLB_BASE), .GLB_SIZE(GLB_SIZE),
        .REG_BASE(REG_BASE), .REG_SIZE(REG_SIZE),
        .TBL_BASE(TBL_BASE), .TBL_SIZE(TBL_SIZE)
    ) u_decode (
        .addr   (bus_addr),
        .region (region)
    );

    pgf_policy u_policy (
        .region    (region),
        .cpu_super (cpu_super),
        .supv_bit  (supv_bit),
        .allow     (allow)
    );

    pgf_supv_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CFG_ADDR(GLB_BASE), .SUPV_POS(SUPV_POS)
    ) u_supv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (rf_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .supv_bit (supv_bit)
    );

    // Forwarded request
    assign rf_addr  = bus_addr;
    assign rf_wdata = bus_wdata;
    assign rf_wr_en = bus_wr & allow;
    assign rf_rd_en = bus_rd & allow;

    // Next-state logic: T_RD_OK, T_RD_BLOCK, T_NO_RD
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (bus_rd && allow)
                    state_d = ST_GRANT;
                else if (bus_rd)
                    state_d = ST_DENY;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rf_rd_en)
                cap_q <= rf_rdata;
        end
    end

    // Outputs per state
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ST_IDLE:  begin rd_valid = 1'b0; rd_data = '0;      end
            ST_GRANT: begin rd_valid = 1'b1; rd_data = cap_q;   end
            ST_DENY:  begin rd_valid = 1'b1; rd_data = BLOCKED; end
            default:  begin rd_valid = 1'b0; rd_data = '0;      end
        endcase
    end
endmodule

// File: rtl/pgf_access_filter_chk.sv
module pgf_access_filter_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int GLB_BASE = 0,
    parameter int GLB_SIZE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              cpu_super,
    input logic [DATA_W-1:0] rf_rdata,
    input logic              rf_wr_en,
    input logic              rf_rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);
    logic in_glb;
    assign in_glb = (32'(bus_addr) >= 32'(GLB_BASE)) &&
                    (32'(bus_addr) <  32'(GLB_BASE + GLB_SIZE));

    a_r2_glb_user_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cpu_super && in_glb) |=> (rd_valid && rd_data == {DATA_W{1'b1}}));

    a_r3_glb_user_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !cpu_super && in_glb) |-> !rf_wr_en);

    a_r4_super_read_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && cpu_super) |=> (rd_valid && rd_data == $past(rf_rdata)));

    a_r5_super_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cpu_super) |-> rf_wr_en);

    a_r10_rd_en_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> bus_rd);

    a_r11_idle_after_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (!rd_valid && rd_data == '0));
endmodule

bind pgf_access_filter pgf_access_filter_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLB_BASE(GLB_BASE), .GLB_SIZE(GLB_SIZE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .cpu_super(cpu_super), .rf_rdata(rf_rdata),
    .rf_wr_en(rf_wr_en), .rf_rd_en(rf_rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data)
);

// File: tb/tb_pgf_access_filter.sv
module tb_pgf_access_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, cpu_super = 1'b0;
    logic [15:0] bus_wdata = '0, rf_rdata = '0;
    logic [7:0]  rf_addr;
    logic [15:0] rf_wdata, rd_data;
    logic        rf_wr_en, rf_rd_en, rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pgf_access_filter dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .cpu_super(cpu_super),
        .rf_rdata(rf_rdata), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .rf_wr_en(rf_wr_en), .rf_rd_en(rf_rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    // vector: super, rd, wr, addr, wdata, rfdata, ok, req number
    typedef struct packed {
        logic        sup;
        logic        rd;
        logic        wr;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [15:0] rfd;
        logic        ok;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 8'h03, 16'h0000, 16'h1234, 1'b0, 4'd2},  // R2
        '{1'b0, 1'b0, 1'b1, 8'h05, 16'hBEEF, 16'h0000, 1'b0, 4'd3},  // R3
        '{1'b1, 1'b1, 1'b0, 8'h03, 16'h0000, 16'hA5A5, 1'b1, 4'd4},  // R4
        '{1'b1, 1'b0, 1'b1, 8'h10, 16'h0F0F, 16'h0000, 1'b1, 4'd5},  // R5
        '{1'b0, 1'b1, 1'b0, 8'h08, 16'h0000, 16'h5555, 1'b0, 4'd6},  // R6
        '{1'b0, 1'b0, 1'b1, 8'h7F, 16'h1111, 16'h0000, 1'b0, 4'd6},  // R6
        '{1'b0, 1'b1, 1'b0, 8'h40, 16'h0000, 16'h7777, 1'b0, 4'd6},  // R6
        '{1'b1, 1'b1, 1'b0, 8'h55, 16'h0000, 16'hC3C3, 1'b1, 4'd4},  // R4
        '{1'b0, 1'b1, 1'b0, 8'h20, 16'h0000, 16'h2222, 1'b0, 4'd9},  // R9
        '{1'b1, 1'b0, 1'b1, 8'h1F, 16'h9999, 16'h0000, 1'b1, 4'd5}   // R5
    };

    task automatic chk(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, check enables mid-cycle, check response after edge
    task automatic access(input logic sup, input logic rd, input logic wr,
                          input logic [7:0] addr, input logic [15:0] wd,
                          input logic [15:0] rfd, input logic ok, input string req);
        logic [15:0] exp_rd;
        @(negedge clk);
        cpu_super = sup; bus_rd = rd; bus_wr = wr;
        bus_addr = addr; bus_wdata = wd; rf_rdata = rfd;
        #1;
        chk(rf_wr_en == (wr & ok), {req, " wr_en"}, 32'(rf_wr_en), 32'(wr & ok));
        chk(rf_rd_en == (rd & ok), {req, " rd_en (R10)"}, 32'(rf_rd_en), 32'(rd & ok));
        if (wr && ok)
            chk(rf_addr == addr && rf_wdata == wd, {req, " fwd"},
                {rf_addr, rf_wdata}, {addr, wd});
        @(posedge clk);
        #1;
        bus_rd = 1'b0; bus_wr = 1'b0;
        if (rd) begin
            exp_rd = ok ? rfd : 16'hFFFF;
            chk(rd_valid && rd_data == exp_rd, {req, " rd_data"},
                {15'd0, rd_valid, rd_data}, {16'd1, exp_rd});
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(rd_valid == 1'b0 && rd_data == 16'h0, "R1 reset outputs",
            {15'd0, rd_valid, rd_data}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk with supervisor bit at its reset value
        for (int i = 0; i < NV; i++)
            access(VEC[i].sup, VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].wdata,
                   VEC[i].rfd, VEC[i].ok, $sformatf("R%0d vec%0d", VEC[i].req, i));

        // R11: idle cycle after a read yields no response
        @(negedge clk);
        @(posedge clk); #1;
        chk(!rd_valid && rd_data == 16'h0, "R11 idle", {15'd0, rd_valid, rd_data}, 32'd0);

        // R8: supervisor clears the bit
        access(1'b1, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h0, 1'b1, "R8 clear");
        // R7: user now allowed in register and table regions
        access(1'b0, 1'b1, 1'b0, 8'h1F, 16'h0, 16'h6B6B, 1'b1, "R7 user rd reg");
        access(1'b0, 1'b0, 1'b1, 8'h40, 16'hABCD, 16'h0, 1'b1, "R7 user wr tbl");
        access(1'b0, 1'b1, 1'b0, 8'h7F, 16'h0, 16'h0101, 1'b1, "R7 user rd tbl");
        // R2/R3: global stays closed
        access(1'b0, 1'b1, 1'b0, 8'h07, 16'h0, 16'h3C3C, 1'b0, "R2 glb bit0");
        access(1'b0, 1'b0, 1'b1, 8'h00, 16'h0080, 16'h0, 1'b0, "R3 glb wr bit0");
        // R8: user write could not set the bit
        access(1'b0, 1'b1, 1'b0, 8'h10, 16'h0, 16'h4E4E, 1'b1, "R8 user no set");
        // R9: unmapped still refused
        access(1'b0, 1'b1, 1'b0, 8'h30, 16'h0, 16'h8888, 1'b0, "R9 gap");
        access(1'b0, 1'b0, 1'b1, 8'h80, 16'h1234, 16'h0, 1'b0, "R9 high wr");
        access(1'b0, 1'b1, 1'b0, 8'hFF, 16'h0, 16'h9999, 1'b0, "R9 high rd");
        // R8: supervisor sets it again, effective next access
        access(1'b1, 1'b0, 1'b1, 8'h00, 16'h0080, 16'h0, 1'b1, "R8 set");
        access(1'b0, 1'b1, 1'b0, 8'h10, 16'h0, 16'h4E4E, 1'b0, "R8 reclosed");

        // R1: reset restores supervisor-only after bit was cleared
        access(1'b1, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h0, 1'b1, "R1 pre-clear");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(1'b0, 1'b1, 1'b0, 8'h10, 16'h0, 16'h7E7E, 1'b0, "R1 after reset");
        access(1'b0, 1'b0, 1'b1, 8'h44, 16'h7E7E, 16'h0, 1'b0, "R1 wr after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule